// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recent virtual-page to physical-page translations. The requester presents a 20-bit virtual page number on the lookup port. In the same cycle the block answers with a hit flag, the matching 20-bit physical page number and the entry's cached dirty bit. The 12-bit page offset never enters the block; the requester joins it to the returned page number.

A mapping may sit in any of the entries. After a miss, the external page walker loads the mapping through the fill port. A fill goes to an empty entry if one exists. Otherwise it replaces the entry that was used least recently. Pages are handled write-back. When a write hits an entry whose dirty bit is clear, the block sets the bit and gives a one-cycle notice carrying the virtual page number, so that outside logic can mark the page-table entry. A flush input empties the whole buffer.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid, every lookup misses and `dirty_upd` is low.
- R2: A lookup hits in the same cycle when a valid entry's tag equals `lk_vpn`. On a hit, `lk_ppn` and `lk_dirty` give that entry's physical page and dirty bit, and at most one entry ever matches.
- R3: A fill writes `fill_vpn`, `fill_ppn` and `fill_dirty` into an entry, and the mapping hits from the next cycle on.
- R4: A fill never displaces a valid entry while an invalid entry exists.
- R5: When every entry is valid, a fill replaces the least recently used entry. A lookup hit or a fill makes its entry the most recently used.
- R6: A write hit (`lk_write`=1) sets the entry's dirty bit from the next cycle on. A read hit leaves the dirty bit unchanged.
- R7: A write hit on an entry whose dirty bit is clear raises `dirty_upd` for exactly the next cycle, with `dirty_upd_vpn` equal to the virtual page number. A write hit on a dirty entry raises nothing.
- R8: `flush` clears every valid bit in one cycle. It takes priority over a fill or a write in the same cycle.
- R9: A fill whose tag is already present overwrites that entry in place. No duplicate is created, and the entry becomes the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppn | output | 20 | Physical page number of the hit |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this access |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_dirty | input | 1 | Initial dirty bit of the installed mapping |
| dirty_upd | output | 1 | One-cycle notice of a first write to a page |
| dirty_upd_vpn | output | 20 | Virtual page number of that page |

## Verification
Lookups are tried against an empty buffer, a partly filled one and a full one. This separates a tag compare that works from false hits on invalid entries. Replacement is tested in two ways. A sequence of fills with no lookups in between shows pure fill order. A sequence where a hit touches the oldest entry shows whether hits count as uses. Write hits on clean entries, read hits and repeated writes separate a first-write notice from a repeated one. A fill of an existing tag, and a fill issued together with a flush, show in-place overwrite and flush priority.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  output logic             dirty_upd,
  output logic [VPN_W-1:0] dirty_upd_vpn
);
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AW-1:0] OLDEST = AW'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, drt_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [AW-1:0]      age_q [ENTRIES];

  logic [ENTRIES-1:0] hit_vec, fmatch_vec, oldest_vec;
  logic [AW-1:0]      hit_idx, victim, touch_idx;
  logic               fmatch, touch_en, wr_hit, upd_d;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g]    = vld_q[g] && (tag_q[g] == lk_vpn);
    assign fmatch_vec[g] = vld_q[g] && (tag_q[g] == fill_vpn);
    assign oldest_vec[g] = (age_q[g] == OLDEST);
  end

  assign fmatch = |fmatch_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = AW'(i);
  end

  always_comb begin
    victim = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (oldest_vec[i]) victim = AW'(i);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld_q[i]) victim = AW'(i);
    for (int i = 0; i < ENTRIES; i++)
      if (fmatch_vec[i]) victim = AW'(i);
  end

  assign lk_hit   = lk_valid && |hit_vec;
  assign lk_ppn   = ppn_q[hit_idx];
  assign lk_dirty = lk_hit && drt_q[hit_idx];

  assign wr_hit    = !flush && lk_hit && lk_write && !(fill_valid && victim == hit_idx);
  assign upd_d     = wr_hit && !drt_q[hit_idx];
  assign touch_en  = !flush && (fill_valid || lk_hit);
  assign touch_idx = fill_valid ? victim : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q         <= '0;
      drt_q         <= '0;
      dirty_upd     <= 1'b0;
      dirty_upd_vpn <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
        age_q[i] <= AW'(i);
      end
    end else begin
      dirty_upd     <= upd_d;
      dirty_upd_vpn <= upd_d ? lk_vpn : dirty_upd_vpn;
      if (flush) begin
        vld_q <= '0;
      end else begin
        if (fill_valid) begin
          vld_q[victim] <= 1'b1;
          tag_q[victim] <= fill_vpn;
          ppn_q[victim] <= fill_ppn;
          drt_q[victim] <= fill_dirty;
        end
        if (wr_hit) drt_q[hit_idx] <= 1'b1;
      end
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++) begin
          if (AW'(i) == touch_idx) age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
    end
  end

  // R2
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  // R5
  single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(oldest_vec));
  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> vld_q == '0);
  // R3
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> (vld_q[$past(victim)] && tag_q[$past(victim)] == $past(fill_vpn)));
  // R6
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !flush && !fill_valid) |=> drt_q[$past(hit_idx)]);
  // R7
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_upd |-> $past(lk_hit && lk_write && !lk_dirty && !flush));
  // R9
  no_dup_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> $onehot(fmatch_vec) || $past(fill_vpn) != fill_vpn);
endmodule

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
  logic clk = 0, rst_n = 0, flush = 0;
  logic lk_valid = 0, lk_write = 0, fill_valid = 0, fill_dirty = 0;
  logic [19:0] lk_vpn = 0, fill_vpn = 0, fill_ppn = 0;
  logic lk_hit, lk_dirty, dirty_upd;
  logic [19:0] lk_ppn, dirty_upd_vpn;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tlb_fa uut (.clk, .rst_n, .flush, .lk_valid, .lk_write, .lk_vpn, .lk_hit, .lk_ppn,
              .lk_dirty, .fill_valid, .fill_vpn, .fill_ppn, .fill_dirty,
              .dirty_upd, .dirty_upd_vpn);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(logic [19:0] v, logic [19:0] p, logic d = 0);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_dirty = d;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic look(string req, logic [19:0] v, logic w, logic ehit,
                      logic [19:0] eppn = 0, logic edirty = 0);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_write = w;
    #1;
    chk(req, lk_hit, ehit);
    if (ehit) begin
      chk(req, lk_ppn, eppn);
      chk(req, lk_dirty, edirty);
    end
    @(negedge clk);
    lk_valid = 0; lk_write = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    chk("R1 upd", dirty_upd, 0);
    look("R1", 20'h00000, 0, 0);
    look("R1", 20'h12345, 0, 0);
  endtask

  task automatic t_fill_lookup();
    fill(20'h00010, 20'hA0010);
    fill(20'h00020, 20'hA0020, 1);
    fill(20'hFFFFF, 20'h0BEEF);
    look("R2", 20'h00010, 0, 1, 20'hA0010, 0);
    look("R3", 20'h00020, 0, 1, 20'hA0020, 1);
    look("R3", 20'hFFFFF, 0, 1, 20'h0BEEF, 0);
    look("R2", 20'h00030, 0, 0);
  endtask

  task automatic t_dirty();
    look("R6 read", 20'h00010, 0, 1, 20'hA0010, 0);
    chk("R7 no upd on read", dirty_upd, 0);
    look("R6 write", 20'h00010, 1, 1, 20'hA0010, 0);
    chk("R7 upd", dirty_upd, 1);
    chk("R7 vpn", dirty_upd_vpn, 20'h00010);
    @(negedge clk);
    chk("R7 one cycle", dirty_upd, 0);
    look("R6 set", 20'h00010, 1, 1, 20'hA0010, 1);
    chk("R7 no upd on dirty", dirty_upd, 0);
    look("R7 dirty fill", 20'h00020, 1, 1, 20'hA0020, 1);
    chk("R7 no upd dirty fill", dirty_upd, 0);
  endtask

  task automatic t_replace();
    do_flush();
    for (int i = 0; i < 8; i++) fill(20'h100 + 20'(i), 20'h200 + 20'(i));
    for (int i = 0; i < 8; i++) look("R4", 20'h100 + 20'(i), 0, 1, 20'h200 + 20'(i), 0);
    look("R5 touch", 20'h100, 0, 1, 20'h200, 0);
    fill(20'h300, 20'h400);
    look("R5 victim", 20'h101, 0, 0);
    look("R5 kept", 20'h100, 0, 1, 20'h200, 0);
    look("R5 new", 20'h300, 0, 1, 20'h400, 0);
  endtask

  task automatic t_dup();
    fill(20'h102, 20'h777);
    look("R9 overwrite", 20'h102, 0, 1, 20'h777, 0);
    fill(20'h301, 20'h401);
    look("R9 mru kept", 20'h102, 0, 1, 20'h777, 0);
    look("R5 next victim", 20'h103, 0, 0);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1; fill_valid = 1; fill_vpn = 20'h555; fill_ppn = 20'h666;
    @(negedge clk);
    flush = 0; fill_valid = 0;
    look("R8", 20'h100, 0, 0);
    look("R8", 20'h300, 0, 0);
    look("R8 fill dropped", 20'h555, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_lookup();
    t_dirty();
    t_replace();
    t_dup();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule